// File: doc/BRIEF.md
# Three-Source Interrupt Flag Controller

This block sits beside a small 4-bit processor core and collects interrupt requests from three places. The first is an 8-bit timer event. The second is an edge on an external pin. The third is a basic interval timer event. Each source has a pending flag that an event sets. Each source also has a mask bit, which software writes through a register port. A single master enable sits above all three mask bits. Two strobes from the core's instruction decoder set and clear the master enable, and software can never read it back.

When at least one source is both pending and unmasked, and the master enable is on, the block raises a request to the core. With the request it gives a fixed-priority index of the winning source. The core answers with an acknowledge pulse. That pulse clears the winner's pending flag and turns the master enable off, so a service routine starts with interrupts closed.

The external pin serves two purposes. It passes through a synchronizer and feeds an edge detector. The same synchronized level can also be read at one status address.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, all pending flags, all mask bits and the master enable are 0. The request output is low and the index reads 3.
- R2: A one-cycle pulse on a timer event input sets that source's pending flag at the next clock edge. A flag is never set without an event.
- R3: The external pin passes through two synchronizer flops. By default, a rising edge of the synchronized level sets the external pending flag one clock later, three clocks after the pin changes. A falling edge sets nothing.
- R4: A source whose mask bit is 0 neither raises the request nor takes part in the priority choice. Its pending flag is kept.
- R5: The set strobe turns the master enable on at the next edge, and the clear strobe turns it off. When both strobes arrive in the same cycle, the clear wins. While the enable is off, the request output stays low.
- R6: The request output is high exactly when the master enable is 1 and at least one source is both pending and unmasked.
- R7: The index encodes the 8-bit timer as 0, the external pin as 1 and the interval timer as 2. It reads 3 when no unmasked source is pending. Priority runs from the external pin, to the 8-bit timer, to the interval timer.
- R8: An acknowledge while the request is high clears only the winning source's pending flag, and it also clears the master enable.
- R9: If the winning source's event arrives in the same cycle as the acknowledge, its pending flag stays 1. The master enable is still cleared.
- R10: A read at address 0xF returns the synchronized pin level in bit 0, with 0 in bits 3:1. A read at any other address returns 0.
- R11: An acknowledge while the request is low changes no flag and leaves the master enable unchanged.
- R12: A mask write loads the written value: bit 0 for the 8-bit timer, bit 1 for the external pin, bit 2 for the interval timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tmr8_evt_i | input | 1 | 8-bit timer event pulse |
| itv_evt_i | input | 1 | Interval timer event pulse |
| ext_pin_i | input | 1 | Asynchronous external interrupt pin |
| gie_set_i | input | 1 | Strobe that turns the master enable on |
| gie_clr_i | input | 1 | Strobe that turns the master enable off |
| en_we_i | input | 1 | Write strobe for the mask bits |
| en_wdata_i | input | 3 | Mask value written when en_we_i is high |
| rd_addr_i | input | 4 | Status read address |
| rd_data_o | output | 4 | Status read data (combinational) |
| irq_o | output | 1 | Interrupt request to the core |
| irq_src_o | output | 2 | Index of the winning source |
| ack_i | input | 1 | Acknowledge pulse from the core |

## Verification
On every cycle, the assertions check the following:
- pending flags rise only on their own events;
- an accepted acknowledge clears or keeps the winner's flag, following the same-cycle event;
- the clear strobe masks the request;
- the external source always wins the index when it is eligible;
- an ignored acknowledge leaves the flags alone;
- each detected pin edge lasts only one cycle.

Only the bench scenarios can show:
- the three-cycle path from pin to flag, and the status read of the pin level;
- the per-source masks holding a flag without losing it;
- the clear strobe winning over a simultaneous set strobe;
- the full priority walk as winners are acknowledged in turn.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int NSRC = 3;

    // source codes double as bit positions in the flag vectors
    typedef enum logic [1:0] {
        SRC_TMR8 = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_ITV  = 2'd2,
        SRC_NONE = 2'd3
    } src_e;

    typedef struct packed {
        logic [NSRC-1:0] pend;
        logic [NSRC-1:0] en;
        logic            gie;
    } ctl_state_t;

endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
    parameter int STAGES = 2,
    parameter bit RISING = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic level_o,
    output logic edge_o
);
    localparam int W = STAGES + 1;

    typedef struct packed {
        logic [W-1:0] sh;
    } pin_state_t;

    pin_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[W-2:0], pin_i};
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign level_o = st_q.sh[STAGES-1];

    generate
        if (RISING) begin : g_rise
            assign edge_o = st_q.sh[STAGES-1] & ~st_q.sh[STAGES];
        end else begin : g_fall
            assign edge_o = ~st_q.sh[STAGES-1] & st_q.sh[STAGES];
        end
    endgenerate

    // R3
    single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_o |=> !edge_o);

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_ctl_pkg::*;
(
    input  logic [NSRC-1:0] req_i,
    output src_e            idx_o
);
    always_comb begin
        if      (req_i[SRC_EXT])  idx_o = SRC_EXT;
        else if (req_i[SRC_TMR8]) idx_o = SRC_TMR8;
        else if (req_i[SRC_ITV])  idx_o = SRC_ITV;
        else                      idx_o = SRC_NONE;
    end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_ctl_pkg::*;
#(
    parameter int             SYNC_STAGES = 2,
    parameter bit             EDGE_RISING = 1'b1,
    parameter int             ADDR_W      = 4,
    parameter int             DATA_W      = 4,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 4'hF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tmr8_evt_i,
    input  logic              itv_evt_i,
    input  logic              ext_pin_i,
    input  logic              gie_set_i,
    input  logic              gie_clr_i,
    input  logic              en_we_i,
    input  logic [NSRC-1:0]   en_wdata_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o,
    output logic [1:0]        irq_src_o,
    input  logic              ack_i
);
    ctl_state_t      st_d, st_q;
    logic            pin_level, pin_edge;
    logic [NSRC-1:0] set_vec, masked;
    src_e            win;
    logic            take;

    irq_pin_edge #(.STAGES(SYNC_STAGES), .RISING(EDGE_RISING)) u_pin (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (ext_pin_i),
        .level_o(pin_level),
        .edge_o (pin_edge)
    );

    irq_prio_pick u_pick (
        .req_i(masked),
        .idx_o(win)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[SRC_TMR8] = tmr8_evt_i;
        set_vec[SRC_EXT]  = pin_edge;
        set_vec[SRC_ITV]  = itv_evt_i;
    end

    assign masked    = st_q.pend & st_q.en;
    assign irq_o     = st_q.gie & (|masked);
    assign irq_src_o = win;
    assign take      = ack_i & irq_o;

    always_comb begin
        st_d = st_q;
        if (en_we_i) st_d.en = en_wdata_i;
        for (int k = 0; k < NSRC; k++) begin
            if (take && (win == src_e'(k))) st_d.pend[k] = 1'b0;
            if (set_vec[k])                 st_d.pend[k] = 1'b1;
        end
        if (gie_set_i)        st_d.gie = 1'b1;
        if (gie_clr_i || take) st_d.gie = 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == STATUS_ADDR) rd_data_o[0] = pin_level;
    end

    // R5
    clr_masks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gie_clr_i |=> !irq_o);

    // R7
    ext_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        masked[SRC_EXT] |-> (irq_src_o == SRC_EXT));

    // R7
    none_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (masked == '0) |-> (irq_src_o == SRC_NONE));

    // R11
    ack_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && !irq_o) |=> (st_q.pend == $past(st_q.pend | set_vec)));

    generate
        for (genvar k = 0; k < NSRC; k++) begin : g_chk
            // R2
            no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (!st_q.pend[k] && !set_vec[k]) |=> !st_q.pend[k]);
            // R8
            ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (take && (win == src_e'(k)) && !set_vec[k]) |=> !st_q.pend[k]);
            // R9
            set_beats_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (take && (win == src_e'(k)) && set_vec[k]) |=> st_q.pend[k]);
        end
    endgenerate

endmodule

// File: tb/irq_flag_ctrl_tb.sv
module irq_flag_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tmr8 = 1'b0, itv = 1'b0, pin = 1'b0;
    logic       gset = 1'b0, gclr = 1'b0, we = 1'b0, ack = 1'b0;
    logic [2:0] wdata = '0;
    logic [3:0] raddr = 4'hF;
    logic [3:0] rdata;
    logic       irq;
    logic [1:0] src;

    int checks = 0, fails = 0;
    bit done = 0;

    typedef struct {
        string      req;
        logic       irq;
        logic [1:0] src;
        logic [3:0] rd;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    irq_flag_ctrl u_dut (
        .clk_i(clk), .rst_ni(rst_n), .tmr8_evt_i(tmr8), .itv_evt_i(itv),
        .ext_pin_i(pin), .gie_set_i(gset), .gie_clr_i(gclr), .en_we_i(we),
        .en_wdata_i(wdata), .rd_addr_i(raddr), .rd_data_o(rdata),
        .irq_o(irq), .irq_src_o(src), .ack_i(ack)
    );

    // monitor: compare design outputs against queued expectations
    always @(negedge clk) begin
        exp_t e;
        if (q.size() != 0) begin
            e = q.pop_front();
            checks++;
            if (irq !== e.irq || src !== e.src || rdata !== e.rd) begin
                fails++;
                $display("FAIL %s: irq=%b src=%0d rd=%h expected irq=%b src=%0d rd=%h",
                         e.req, irq, src, rdata, e.irq, e.src, e.rd);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic expect_o(string r, logic i, logic [1:0] s, logic [3:0] d);
        q.push_back('{r, i, s, d});
        @(negedge clk); #1;
    endtask

    task automatic pulse_tmr();  tmr8 = 1; tick(); tmr8 = 0; endtask
    task automatic pulse_itv();  itv  = 1; tick(); itv  = 0; endtask
    task automatic pulse_set();  gset = 1; tick(); gset = 0; endtask
    task automatic pulse_clr();  gclr = 1; tick(); gclr = 0; endtask
    task automatic pulse_ack();  ack  = 1; tick(); ack  = 0; endtask
    task automatic wr_en(logic [2:0] v); we = 1; wdata = v; tick(); we = 0; endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1; tick();
        expect_o("R1 reset state", 0, 3, 0);
        wr_en(3'b111); pulse_set();
        expect_o("R1 no flags after reset", 0, 3, 0);

        pulse_tmr();
        expect_o("R2 R6 timer event raises request", 1, 0, 0);
        pulse_ack();
        expect_o("R8 ack clears winner and enable", 0, 3, 0);
        pulse_set();
        expect_o("R8 flag stays cleared", 0, 3, 0);

        wr_en(3'b110); pulse_tmr();
        expect_o("R4 masked source silent", 0, 3, 0);
        wr_en(3'b111);
        expect_o("R4 flag kept while masked", 1, 0, 0);

        pulse_clr();
        expect_o("R5 clear strobe masks", 0, 0, 0);
        gset = 1; gclr = 1; tick(); gset = 0; gclr = 0;
        expect_o("R5 clear wins over set", 0, 0, 0);
        pulse_set();
        expect_o("R5 set strobe enables", 1, 0, 0);

        pulse_itv();
        expect_o("R7 timer beats interval", 1, 0, 0);
        pin = 1; tick(); tick();
        expect_o("R10 level after two flops", 1, 0, 1);
        tick();
        expect_o("R3 R7 pin edge flag and priority", 1, 1, 1);

        pulse_ack();
        expect_o("R8 ext cleared only", 0, 0, 1);
        pulse_set();
        expect_o("R7 timer next", 1, 0, 1);
        pulse_ack();
        expect_o("R8 timer cleared", 0, 2, 1);
        pulse_set();
        expect_o("R7 interval last", 1, 2, 1);
        pulse_ack();
        expect_o("R8 all cleared", 0, 3, 1);

        pin = 0; repeat (4) tick(); pulse_set();
        expect_o("R3 falling edge ignored", 0, 3, 0);

        pulse_tmr();
        expect_o("R9 setup", 1, 0, 0);
        ack = 1; tmr8 = 1; tick(); ack = 0; tmr8 = 0;
        expect_o("R9 set beats ack", 0, 0, 0);
        pulse_set();
        expect_o("R9 flag still pending", 1, 0, 0);
        pulse_ack();
        expect_o("R9 later ack clears", 0, 3, 0);

        pulse_set(); wr_en(3'b000); pulse_tmr();
        expect_o("R11 masked pending", 0, 3, 0);
        pulse_ack();
        wr_en(3'b111);
        expect_o("R11 ack ignored while idle", 1, 0, 0);
        pulse_ack();
        expect_o("R11 cleanup", 0, 3, 0);

        pin = 1; repeat (3) tick();
        expect_o("R10 status high", 0, 1, 1);
        raddr = 4'h3;
        expect_o("R10 other address zero", 0, 1, 0);
        raddr = 4'hF;

        pulse_tmr(); wr_en(3'b010);
        expect_o("R12 bit1 selects ext", 0, 1, 1);
        wr_en(3'b001);
        expect_o("R12 bit0 selects timer", 0, 0, 1);
        pulse_itv(); wr_en(3'b100);
        expect_o("R12 bit2 selects interval", 0, 2, 1);
        wr_en(3'b000);
        expect_o("R12 all masked", 0, 3, 1);

        tick();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule